// File: doc/BRIEF.md
# Quorum Tick Generator

This block is the tick source of one node in a distributed clock built from n = 3f+1 nodes, where up to f nodes may be faulty in any way. Each node keeps a per-peer tracker for each of the other 3f nodes. Every tracker reports two flags. The "ahead" flag says that the peer has issued more ticks than the local node. The "reach" flag says that the peer's tick number plus the pipelining depth X is at least the local count. Flag generation is outside this block. The block counts how many flags of each kind are set. It then emits single-cycle tick pulses that form the local clock and go back to every tracker.

After reset the node fires a burst of X+1 ticks, so its count starts at X+1. This pipelined start lets a peer's tick k justify local tick k+X+1. In the steady state two quorum rules apply. If at least f+1 peers are ahead, the node catches up by one tick per cycle for as long as the condition lasts. If at least 2f+1 peers reach the local count, the node advances by one tick. A cycle fires at most one tick, even when both rules hold. The tick counter is a W-bit unsigned value that wraps.

Top module: `quorum_tick_gen`

## Requirements
- R1: While reset is asserted, `tick_o` is 0 and `clock_o` is 0, whatever the flag inputs are.
- R2: After reset is released, `tick_o` is high for exactly PIPE_X+1 consecutive cycles. The first pulse appears one clock edge after release, and `clock_o` reaches PIPE_X+1.
- R3: The flag inputs have no effect during the start-up burst. With every flag set throughout the burst, the burst still gives exactly PIPE_X+1 ticks.
- R4: After the burst, a cycle in which at least FAULTS+1 ahead flags are set produces a tick pulse one edge later.
- R5: With only FAULTS ahead flags set and fewer than 2*FAULTS+1 reach flags set, no tick is produced.
- R6: After the burst, a cycle in which at least 2*FAULTS+1 reach flags are set produces a tick pulse one edge later.
- R7: With 2*FAULTS reach flags set and fewer than FAULTS+1 ahead flags set, no tick is produced.
- R8: At most one tick is produced per cycle. A catch-up condition held for k cycles yields exactly k ticks, and this holds even when both rules are true at once.
- R9: `clock_o` rises by exactly one, modulo 2^CNT_W, on each tick and holds its value otherwise. It wraps from 2^CNT_W-1 to 0.
- R10: `tick_o` is a registered pulse. A single qualifying cycle gives a pulse that is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ahead_flags_i | input | 3*FAULTS | One per peer: the peer has issued more ticks than the local count |
| reach_flags_i | input | 3*FAULTS | One per peer: the peer's tick number plus PIPE_X is at least the local count |
| tick_o | output | 1 | Registered local tick pulse |
| clock_o | output | CNT_W | Local tick count, wrapping |

## Verification
The bench targets the quorum boundaries at f and f+1 ahead flags and at 2f and 2f+1 reach flags. A comparator off by one would tick early or stall there. It fills every flag during the burst and clears them on its last cycle. A design that enabled the rules too early, or lost the burst length, would end at a count other than X+1. Holding both rules true together catches a design that fires twice or skips cycles. A full wrap of the counter catches a broken step from all-ones to zero.

// File: rtl/quorum_tick_pkg.sv
package quorum_tick_pkg;
   // quorum sizes derived from the fault budget
   function automatic int catchup_quorum(input int faults);
      return faults + 1;
   endfunction

   function automatic int advance_quorum(input int faults);
      return 2 * faults + 1;
   endfunction

   function automatic int peer_count(input int faults);
      return 3 * faults;
   endfunction

   // which structure a quorum detector is built from
   typedef enum logic [1:0] {
      QV_ANY   = 2'd0,
      QV_ALL   = 2'd1,
      QV_COUNT = 2'd2
   } quorum_variant_e;

   function automatic quorum_variant_e pick_variant(input int width, input int thresh);
      if (thresh == 1)          return QV_ANY;
      else if (thresh == width) return QV_ALL;
      else                      return QV_COUNT;
   endfunction
endpackage

// File: rtl/flag_quorum.sv
module flag_quorum
   import quorum_tick_pkg::*;
#(
   parameter int WIDTH  = 3,
   parameter int THRESH = 2
) (
   input  logic [WIDTH-1:0] flags_i,
   output logic             hit_o
);
   localparam quorum_variant_e VARIANT = pick_variant(WIDTH, THRESH);
   localparam int CW = $clog2(WIDTH + 1);

   if (THRESH < 1 || THRESH > WIDTH) begin : g_bad_thresh
      $error("flag_quorum: THRESH must lie in 1..WIDTH");
   end

   if (VARIANT == QV_ANY) begin : g_any
      assign hit_o = |flags_i;
   end else if (VARIANT == QV_ALL) begin : g_all
      assign hit_o = &flags_i;
   end else begin : g_count
      logic [CW-1:0] partial [WIDTH+1];
      assign partial[0] = '0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_add
         assign partial[i+1] = partial[i] + CW'(flags_i[i]);
      end
      assign hit_o = (partial[WIDTH] >= CW'(THRESH));

      always_comb begin
         p_count_range_r4: assert (partial[WIDTH] <= CW'(WIDTH));
      end
   end
endmodule

// File: rtl/boot_burst.sv
module boot_burst #(
   parameter int BURST = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic active_o
);
   localparam int BW = $clog2(BURST + 1);

   if (BURST < 1) begin : g_bad_burst
      $error("boot_burst: BURST must be at least 1");
   end

   logic [BW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            left_q <= BW'(BURST);
      else if (left_q != '0)  left_q <= left_q - BW'(1);
   end

   assign active_o = (left_q != '0);

   p_burst_drains_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_o |=> !active_o);
endmodule

// File: rtl/tick_stage.sv
module tick_stage #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fire_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] clock_o
);
   logic             tick_q;
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_q  <= 1'b0;
         count_q <= '0;
      end else begin
         tick_q <= fire_i;
         if (fire_i) count_q <= count_q + CNT_W'(1);
      end
   end

   assign tick_o  = tick_q;
   assign clock_o = count_q;

   p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> (clock_o == CNT_W'($past(clock_o) + 1'b1)));
   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_o |-> $stable(clock_o));
endmodule

// File: rtl/quorum_tick_gen.sv
module quorum_tick_gen
   import quorum_tick_pkg::*;
#(
   parameter int FAULTS = 1,
   parameter int PIPE_X = 4,
   parameter int CNT_W  = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [3*FAULTS-1:0]     ahead_flags_i,
   input  logic [3*FAULTS-1:0]     reach_flags_i,
   output logic                    tick_o,
   output logic [CNT_W-1:0]        clock_o
);
   localparam int PEERS   = peer_count(FAULTS);
   localparam int Q_CATCH = catchup_quorum(FAULTS);
   localparam int Q_ADV   = advance_quorum(FAULTS);
   localparam int BURST   = PIPE_X + 1;

   if (FAULTS < 1) begin : g_bad_faults
      $error("quorum_tick_gen: FAULTS must be at least 1");
   end
   if (PIPE_X < 0) begin : g_bad_pipe
      $error("quorum_tick_gen: PIPE_X must not be negative");
   end
   if (CNT_W < 2 || (64'd1 << CNT_W) <= 64'(BURST)) begin : g_bad_width
      $error("quorum_tick_gen: CNT_W too narrow for the start-up burst");
   end

   logic ahead_hit, reach_hit, boot_active, fire;

   flag_quorum #(.WIDTH(PEERS), .THRESH(Q_CATCH)) u_catch (
      .flags_i (ahead_flags_i),
      .hit_o   (ahead_hit)
   );

   flag_quorum #(.WIDTH(PEERS), .THRESH(Q_ADV)) u_adv (
      .flags_i (reach_flags_i),
      .hit_o   (reach_hit)
   );

   boot_burst #(.BURST(BURST)) u_boot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_o (boot_active)
   );

   // burst has priority; the quorum rules are gated off until it drains
   assign fire = boot_active | (ahead_hit | reach_hit);

   tick_stage #(.CNT_W(CNT_W)) u_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire),
      .tick_o  (tick_o),
      .clock_o (clock_o)
   );

   p_boot_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_active |=> tick_o);
   p_catchup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!boot_active && ahead_hit) |=> tick_o);
   p_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!boot_active && reach_hit) |=> tick_o);
   p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!boot_active && !ahead_hit && !reach_hit) |=> !tick_o);
   p_reset_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (!tick_o && clock_o == '0));
endmodule

// File: tb/quorum_tick_gen_tb_top.sv
`timescale 1ns/1ps
module quorum_tick_gen_tb_top;
   localparam int FAULTS = 1;
   localparam int PIPE_X = 4;
   localparam int CNT_W  = 8;
   localparam int NR     = 3 * FAULTS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NR-1:0]    ahead = '0;
   logic [NR-1:0]    reach = '0;
   logic             tick;
   logic [CNT_W-1:0] clock_val;

   int checks = 0;
   int errors = 0;
   logic [CNT_W-1:0] exp_clk = '0;

   always #4 clk = ~clk;

   quorum_tick_gen #(.FAULTS(FAULTS), .PIPE_X(PIPE_X), .CNT_W(CNT_W)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .ahead_flags_i (ahead),
      .reach_flags_i (reach),
      .tick_o        (tick),
      .clock_o       (clock_val)
   );

   function automatic logic [NR-1:0] low_bits(input int n);
      logic [NR-1:0] m = '0;
      for (int i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // drive at a falling edge, wait one cycle, check at the next falling edge
   task automatic cyc(input string req, input logic [NR-1:0] a, input logic [NR-1:0] r,
                      input logic exp_tick);
      ahead = a;
      reach = r;
      @(negedge clk);
      if (exp_tick) exp_clk = exp_clk + CNT_W'(1);
      check({req, " tick"}, int'(tick), int'(exp_tick));
      check({req, " clock"}, int'(clock_val), int'(exp_clk));
   endtask

   // R1 reset, then R2/R3 burst with given flags held during it
   task automatic t_reset_boot(input logic [NR-1:0] burst_flags);
      ahead = burst_flags;
      reach = burst_flags;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 tick in reset", int'(tick), 0);
      check("R1 clock in reset", int'(clock_val), 0);
      exp_clk = '0;
      rst_n = 1'b1;
      for (int k = 1; k <= PIPE_X + 1; k++) begin
         @(negedge clk);
         exp_clk = CNT_W'(k);
         check("R2 burst tick", int'(tick), 1);
         check("R2 burst clock", int'(clock_val), k);
      end
      // flags cleared exactly as the burst ends: R3
      cyc("R3 burst end", '0, '0, 1'b0);
      check("R3 burst length", int'(clock_val), PIPE_X + 1);
   endtask

   task automatic t_catchup();
      cyc("R4 catch-up low", low_bits(FAULTS + 1), '0, 1'b1);
      cyc("R8 catch-up held", low_bits(FAULTS + 1), '0, 1'b1);
      cyc("R8 catch-up held", low_bits(FAULTS + 1) << (NR - FAULTS - 1), '0, 1'b1);
      cyc("R4 catch-up released", '0, '0, 1'b0);
   endtask

   task automatic t_below_quorum();
      cyc("R5 f ahead", low_bits(FAULTS), '0, 1'b0);
      cyc("R5 f ahead high bits", low_bits(FAULTS) << (NR - FAULTS), '0, 1'b0);
      cyc("R7 2f reach", '0, low_bits(2 * FAULTS), 1'b0);
      cyc("R7 2f reach shifted", '0, low_bits(2 * FAULTS) << (NR - 2 * FAULTS), 1'b0);
      cyc("R5 R7 both short", low_bits(FAULTS), low_bits(2 * FAULTS), 1'b0);
   endtask

   task automatic t_advance();
      cyc("R6 advance", '0, low_bits(2 * FAULTS + 1), 1'b1);
      cyc("R10 single pulse", '0, '0, 1'b0);
      cyc("R10 still idle", '0, '0, 1'b0);
   endtask

   task automatic t_both();
      cyc("R8 both rules", '1, '1, 1'b1);
      cyc("R8 both rules", '1, '1, 1'b1);
      cyc("R8 both released", '0, '0, 1'b0);
   endtask

   task automatic t_wrap();
      logic [CNT_W-1:0] start = exp_clk;
      logic seen_wrap = 1'b0;
      for (int i = 0; i < (1 << CNT_W); i++) begin
         cyc("R9 wrap run", '0, '1, 1'b1);
         if (clock_val == '0) seen_wrap = 1'b1;
      end
      check("R9 back to start", int'(clock_val), int'(start));
      check("R9 passed zero", int'(seen_wrap), 1);
      cyc("R9 hold after wrap", '0, '0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_boot('0);
      t_catchup();
      t_below_quorum();
      t_advance();
      t_both();
      t_wrap();
      t_reset_boot('1);
      t_catchup();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule